// File: doc/BRIEF.md
# Matrix Extension Instruction Trap Classifier

This block inspects each decoded instruction against the current streaming-mode bit and the matrix-storage enable bit and decides whether the instruction must trap. A trap comes from one of three causes: an instruction barred in streaming mode issued while streaming mode is on, an instruction allowed only in streaming mode issued while streaming mode is off, or an instruction that touches matrix storage (including the lookup-table storage of the second-generation extension) while that storage is disabled. Each cause shares one exception class and carries its own sub-code, so the exception logic downstream can tell them apart.

The classifier is purely combinational and holds no state. It also tells the vector datapath which vector length applies: the streaming length when streaming mode is on, the normal length otherwise. The decision applies at every privilege level, so the block takes no privilege input. Exception entry and updates to architectural state are handled elsewhere.

Top module: `mx_trap_classifier`

## Requirements
- R1: When no trap condition holds, trap_o is 0 and both ec_o and subcode_o are 0.
- R2: An instruction with uses_mat_i=1 while za_i=0, and no mode trap, gives trap_o=1, ec_o=0x1D and subcode_o=3.
- R3: An instruction with bad_in_strm_i=1 while sm_i=1 gives trap_o=1, ec_o=0x1D and subcode_o=1.
- R4: An instruction with strm_only_i=1 while sm_i=0 gives trap_o=1, ec_o=0x1D and subcode_o=2.
- R5: When a mode trap (R3 or R4) and the storage trap (R2) both hold, the mode trap's sub-code is reported.
- R6: vl_sel_o equals sm_i for every input pattern (1 selects the streaming vector length, 0 the normal one).
- R7: With za_i=1 the storage attribute never causes a trap; with sm_i=1 the streaming-only attribute never causes a trap; with sm_i=0 the barred-in-streaming attribute never causes a trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sm_i | input | 1 | Streaming mode active |
| za_i | input | 1 | Matrix storage enabled |
| uses_mat_i | input | 1 | Instruction can access matrix or lookup-table storage |
| bad_in_strm_i | input | 1 | Instruction is barred in streaming mode |
| strm_only_i | input | 1 | Instruction is allowed only in streaming mode |
| trap_o | output | 1 | Instruction must trap |
| ec_o | output | 6 | Exception class, 0x1D on a trap, else 0 |
| subcode_o | output | 2 | Trap cause: 1 barred in streaming, 2 streaming only, 3 storage off, 0 none |
| vl_sel_o | output | 1 | 1 selects streaming vector length, 0 normal length |

## Verification
The hardest situation to reach is the overlap of a mode trap and a disabled-storage trap, where only priority decides the sub-code; it needs an instruction flagged as a storage user together with a mode attribute, in the matching mode, with storage disabled. Because the block has just five input bits, the stimulus sweeps all 32 patterns, so every overlap, including attribute combinations that a real decoder would never produce, is visited and compared with a sub-code computed from the priority rule.

// File: rtl/mx_trap_pkg.sv
package mx_trap_pkg;
  parameter int EC_W  = 6;
  parameter int SUB_W = 2;
  parameter logic [EC_W-1:0] EC_MATRIX = 6'h1D;

  typedef enum logic [SUB_W-1:0] {
    SUB_NONE      = 2'd0,
    SUB_BAR_STRM  = 2'd1,
    SUB_STRM_ONLY = 2'd2,
    SUB_STORE_OFF = 2'd3
  } sub_e;

  typedef struct packed {
    logic hit;
    sub_e code;
  } cause_t;
endpackage

// File: rtl/mx_mode_check.sv
module mx_mode_check
  import mx_trap_pkg::*;
(
  input  logic   sm_i,
  input  logic   bad_in_strm_i,
  input  logic   strm_only_i,
  output cause_t cause_o
);
  always_comb begin
    cause_o = '{hit: 1'b0, code: SUB_NONE};
    if (sm_i && bad_in_strm_i)       cause_o = '{hit: 1'b1, code: SUB_BAR_STRM};
    else if (!sm_i && strm_only_i)   cause_o = '{hit: 1'b1, code: SUB_STRM_ONLY};
  end
endmodule

// File: rtl/mx_store_check.sv
module mx_store_check
  import mx_trap_pkg::*;
(
  input  logic   za_i,
  input  logic   uses_mat_i,
  output cause_t cause_o
);
  always_comb begin
    cause_o.hit  = uses_mat_i && !za_i;
    cause_o.code = cause_o.hit ? SUB_STORE_OFF : SUB_NONE;
  end
endmodule

// File: rtl/mx_trap_select.sv
module mx_trap_select
  import mx_trap_pkg::*;
(
  input  cause_t            mode_i,
  input  cause_t            store_i,
  output logic              trap_o,
  output logic [EC_W-1:0]   ec_o,
  output logic [SUB_W-1:0]  subcode_o
);
  cause_t win;

  // mode legality outranks storage enable
  always_comb begin
    if (mode_i.hit) win = mode_i;
    else            win = store_i;
    trap_o    = win.hit;
    ec_o      = win.hit ? EC_MATRIX : '0;
    subcode_o = win.hit ? win.code : SUB_NONE;
  end
endmodule

// File: rtl/mx_trap_classifier.sv
module mx_trap_classifier
  import mx_trap_pkg::*;
(
  input  logic              sm_i,
  input  logic              za_i,
  input  logic              uses_mat_i,
  input  logic              bad_in_strm_i,
  input  logic              strm_only_i,
  output logic              trap_o,
  output logic [EC_W-1:0]   ec_o,
  output logic [SUB_W-1:0]  subcode_o,
  output logic              vl_sel_o
);
  cause_t mode_cause;
  cause_t store_cause;

  mx_mode_check u_mode (
    .sm_i          (sm_i),
    .bad_in_strm_i (bad_in_strm_i),
    .strm_only_i   (strm_only_i),
    .cause_o       (mode_cause)
  );

  mx_store_check u_store (
    .za_i       (za_i),
    .uses_mat_i (uses_mat_i),
    .cause_o    (store_cause)
  );

  mx_trap_select u_sel (
    .mode_i    (mode_cause),
    .store_i   (store_cause),
    .trap_o    (trap_o),
    .ec_o      (ec_o),
    .subcode_o (subcode_o)
  );

  assign vl_sel_o = sm_i;
endmodule

// File: rtl/mx_trap_classifier_chk.sv
module mx_trap_classifier_chk
  import mx_trap_pkg::*;
(
  input logic              sm_i,
  input logic              za_i,
  input logic              uses_mat_i,
  input logic              bad_in_strm_i,
  input logic              strm_only_i,
  input logic              trap_o,
  input logic [EC_W-1:0]   ec_o,
  input logic [SUB_W-1:0]  subcode_o,
  input logic              vl_sel_o
);
  always_comb begin
    if (!trap_o) begin
      assert_quiet_outputs_R1: assert (ec_o == '0 && subcode_o == '0);
    end
    if (trap_o) begin
      assert_class_on_trap_R2: assert (ec_o == EC_MATRIX);
    end
    if (sm_i && bad_in_strm_i) begin
      assert_bar_in_strm_R3: assert (trap_o && subcode_o == 2'd1);
    end
    if (!sm_i && strm_only_i) begin
      assert_strm_only_R4: assert (trap_o && subcode_o == 2'd2);
    end
    if (uses_mat_i && !za_i && !(sm_i ? bad_in_strm_i : strm_only_i)) begin
      assert_store_off_R2: assert (trap_o && subcode_o == 2'd3);
    end
    if (uses_mat_i && !za_i && (sm_i ? bad_in_strm_i : strm_only_i)) begin
      assert_mode_wins_R5: assert (subcode_o != 2'd3);
    end
    assert_vl_follows_mode_R6: assert (vl_sel_o == sm_i);
    if (!(sm_i ? bad_in_strm_i : strm_only_i) && !(uses_mat_i && !za_i)) begin
      assert_no_spurious_R7: assert (!trap_o);
    end
  end
endmodule

bind mx_trap_classifier mx_trap_classifier_chk u_chk (
  .sm_i          (sm_i),
  .za_i          (za_i),
  .uses_mat_i    (uses_mat_i),
  .bad_in_strm_i (bad_in_strm_i),
  .strm_only_i   (strm_only_i),
  .trap_o        (trap_o),
  .ec_o          (ec_o),
  .subcode_o     (subcode_o),
  .vl_sel_o      (vl_sel_o)
);

// File: tb/mx_trap_classifier_bench.sv
module mx_trap_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       sm, za, mat, bad, only;
  logic       trap, vl;
  logic [5:0] ec;
  logic [1:0] sub;
  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mx_trap_classifier u_mx_trap_classifier (
    .sm_i          (sm),
    .za_i          (za),
    .uses_mat_i    (mat),
    .bad_in_strm_i (bad),
    .strm_only_i   (only),
    .trap_o        (trap),
    .ec_o          (ec),
    .subcode_o     (sub),
    .vl_sel_o      (vl)
  );

  task automatic check(input int act, input int exp, input string req, input int pat);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s pattern %0d: actual %0d expected %0d", req, pat, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    {only, bad, mat, za, sm} = '0;
    @(negedge clk);
    // idle pattern: R1
    check(trap, 0, "R1", 0);
    check(ec, 0, "R1", 0);
    check(sub, 0, "R1", 0);
    for (int v = 0; v < 32; v++) begin
      @(posedge clk);
      {only, bad, mat, za, sm} = v[4:0];
      @(negedge clk);
      begin
        int mode_hit, store_hit, exp_sub, exp_trap;
        string req;
        mode_hit  = (v[0] && v[3]) || (!v[0] && v[4]);
        store_hit = v[2] && !v[1];
        if (v[0] && v[3])       begin exp_sub = 1; req = (store_hit != 0) ? "R5" : "R3"; end
        else if (!v[0] && v[4]) begin exp_sub = 2; req = (store_hit != 0) ? "R5" : "R4"; end
        else if (store_hit != 0) begin exp_sub = 3; req = "R2"; end
        else                    begin exp_sub = 0; req = (v[2] || v[3] || v[4]) ? "R7" : "R1"; end
        exp_trap = (mode_hit != 0 || store_hit != 0) ? 1 : 0;
        check(trap, exp_trap, req, v);
        check(ec, exp_trap * 29, req, v);
        check(sub, exp_sub, req, v);
        check(vl, v[0], "R6", v);
      end
    end
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule